// File: doc/BRIEF.md
# WOTS+ Hash Chain Sequencer

This block walks a Winternitz one-time signature hash chain. It takes a 256-bit starting value, a starting position, a step count, a chain length parameter, a 256-bit public seed and a 256-bit address word. It then applies the chain step the requested number of times. Every step derives a key and a bitmask with two keyed PRF calls and compresses the masked running value with one F call. The block does not contain a hash core. It drives an external sponge with a 128-bit rate through a one-request-at-a-time port that has three signals: a start request, a continue request and a done pulse.

A host drives `go` for one cycle with the operands on the inputs. The block captures the operands, checks the requested range and either rejects the request or runs the chain. When the last step completes it pulses `done`, and the chain value stays on `result` until the next accepted request. While a chain runs, the operand inputs may change without effect.

Top module: `wots_chain_seq`

## Requirements
- R1: After reset `busy`, `done`, `chain_err`, `sp_start` and `sp_cont` are low and `result` is zero.
- R2: A `go` in idle is rejected when pos_i + steps_j + 1 > w_par; a w_par of zero therefore always rejects. On rejection `chain_err` is high from the next cycle until the next accepted `go`. There is no `done` pulse, no sponge request is issued and `result` keeps its value.
- R3: An accepted `go` with steps_j = 0 issues no sponge request, pulses `done` in the next cycle and sets `result` to chain_in.
- R4: For chain step k (from 0), both PRF calls take the input seed (bits 511:256) followed by the captured address word (bits 255:0). In that address word, bits 63:32 are replaced by pos_i + k and bits 31:0 by 0 for the key call or 1 for the mask call. All other address bits are unchanged.
- R5: Each step replaces the running value v with F(key, v XOR mask), where the F input is the key (bits 511:256) followed by v XOR mask (bits 255:0).
- R6: Each call issues five requests. The first is a start request and the other four are continue requests. The first four carry the 512-bit input in 128-bit blocks, most significant first, and the fifth carries a zero block (squeeze). The 256-bit call output is the sponge output after the fourth block (bits 255:128) followed by the output after the squeeze (bits 127:0).
- R7: At most one sponge request is outstanding. Each request lasts one cycle, and the next request is issued only after `sp_done` has been seen.
- R8: `done` is a one-cycle pulse after the last step. After it, `result` holds the chain value until another `go` is accepted.
- R9: A `go` that arrives while `busy` is high is ignored, including its operands.
- R10: Within each step the calls run in the order key, mask, F, so a chain of j steps issues exactly 15·j requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go | input | 1 | One-cycle request to start a chain |
| chain_in | input | 256 | Starting chain value |
| seed | input | 256 | Public seed keying the PRF calls |
| addr | input | 256 | Address word template |
| pos_i | input | 8 | Starting chain position |
| steps_j | input | 8 | Number of steps to apply |
| w_par | input | 8 | Winternitz parameter (chain length) |
| busy | output | 1 | Chain in progress |
| done | output | 1 | One-cycle completion pulse |
| chain_err | output | 1 | Last request was out of range |
| result | output | 256 | Chain value |
| sp_start | output | 1 | Sponge request from zero state |
| sp_cont | output | 1 | Sponge request continuing the state |
| sp_blk | output | 128 | Block carried with a request |
| sp_done | input | 1 | Sponge completion pulse |
| sp_out | input | 128 | Sponge output block |

## Verification
Two things can happen in the same cycle. A new `go` can arrive while the sequencer waits for a sponge reply, and the final F result can be captured while `done` is raised. The bench drives a `go` with different operands and changed input buses in the middle of a running chain. It then judges the outcome only by the final `result`, which must match a bench model of the original chain, and by the request count. The bench also checks that the last step's value and the `done` pulse appear together in one cycle and that `done` drops in the next cycle.

// File: rtl/wcs_pkg.sv
package wcs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } wcs_state_e;

  typedef enum logic [1:0] {
    PH_KEY  = 2'd0,
    PH_MASK = 2'd1,
    PH_FN   = 2'd2
  } wcs_phase_e;
endpackage

// File: rtl/wcs_rst_sync.sv
module wcs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sh_q[STAGES-1];
endmodule

// File: rtl/wcs_ctrl.sv
module wcs_ctrl
  import wcs_pkg::*;
#(
  parameter int CW  = 8,
  parameter int NB  = 4,
  parameter int BIW = $clog2(NB + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           go,
  input  logic [CW-1:0]  pos_i,
  input  logic [CW-1:0]  steps_j,
  input  logic [CW-1:0]  w_par,
  input  logic           sp_done,
  output wcs_phase_e     phase,
  output logic [BIW-1:0] blk_idx,
  output logic [CW-1:0]  pos,
  output logic           accept,
  output logic           cap_hi,
  output logic           cap_out,
  output logic           busy,
  output logic           done,
  output logic           chain_err,
  output logic           sp_start,
  output logic           sp_cont
);
  wcs_state_e     st_q, st_n;
  wcs_phase_e     ph_q, ph_n;
  logic [BIW-1:0] blk_q, blk_n;
  logic [CW-1:0]  step_q, step_n;
  logic [CW-1:0]  i_q, j_q;
  logic           done_q, done_n;
  logic           err_q, err_n;
  logic [CW:0]    span;
  logic           in_range;
  logic           last_blk;
  logic           last_step;

  assign span      = {1'b0, pos_i} + {1'b0, steps_j} + {{CW{1'b0}}, 1'b1};
  assign in_range  = span <= {1'b0, w_par};
  assign accept    = go && (st_q == ST_IDLE) && in_range;
  assign last_blk  = blk_q == BIW'(NB);
  assign last_step = (step_q + 1'b1) == j_q;

  always_comb begin
    st_n   = st_q;
    ph_n   = ph_q;
    blk_n  = blk_q;
    step_n = step_q;
    done_n = 1'b0;
    err_n  = err_q;
    case (st_q)
      ST_IDLE: begin
        if (go) begin
          if (!in_range) begin
            err_n = 1'b1;
          end else begin
            err_n  = 1'b0;
            ph_n   = PH_KEY;
            blk_n  = '0;
            step_n = '0;
            if (steps_j == '0) done_n = 1'b1;
            else               st_n   = ST_REQ;
          end
        end
      end
      ST_REQ: st_n = ST_WAIT;
      ST_WAIT: begin
        if (sp_done) begin
          if (!last_blk) begin
            blk_n = blk_q + 1'b1;
            st_n  = ST_REQ;
          end else begin
            blk_n = '0;
            case (ph_q)
              PH_KEY:  begin ph_n = PH_MASK; st_n = ST_REQ; end
              PH_MASK: begin ph_n = PH_FN;   st_n = ST_REQ; end
              default: begin
                ph_n = PH_KEY;
                if (last_step) begin
                  st_n   = ST_IDLE;
                  done_n = 1'b1;
                end else begin
                  step_n = step_q + 1'b1;
                  st_n   = ST_REQ;
                end
              end
            endcase
          end
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      ph_q   <= PH_KEY;
      blk_q  <= '0;
      step_q <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_n;
      ph_q   <= ph_n;
      blk_q  <= blk_n;
      step_q <= step_n;
      done_q <= done_n;
      err_q  <= err_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      i_q <= '0;
      j_q <= '0;
    end else if (accept) begin
      i_q <= pos_i;
      j_q <= steps_j;
    end
  end

  assign phase     = ph_q;
  assign blk_idx   = blk_q;
  assign pos       = i_q + step_q;
  assign busy      = st_q != ST_IDLE;
  assign done      = done_q;
  assign chain_err = err_q;
  assign sp_start  = (st_q == ST_REQ) && (blk_q == '0);
  assign sp_cont   = (st_q == ST_REQ) && (blk_q != '0);
  assign cap_hi    = (st_q == ST_WAIT) && sp_done && (blk_q == BIW'(NB - 1));
  assign cap_out   = (st_q == ST_WAIT) && sp_done && last_blk;

  // R7: a request is never followed directly by another one
  assert_req_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_start || sp_cont) |=> !(sp_start || sp_cont));
  // R8: completion is a single-cycle pulse
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R2: a rejected request never completes
  assert_err_nodone_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(chain_err && done));
  // R9: a go while busy leaves the captured operands alone
  assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && go) |=> ($stable(j_q) && $stable(i_q)));
  // R10: the step counter stays below the requested count while running
  assert_step_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (step_q < j_q));
  // R3: a zero-length chain never issues a request
  assert_zero_noreq_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && steps_j == '0) |=> !busy);
endmodule

// File: rtl/wcs_msg.sv
module wcs_msg
  import wcs_pkg::*;
#(
  parameter int DW     = 256,
  parameter int RW     = 128,
  parameter int CW     = 8,
  parameter int HA_LSB = 32,
  parameter int KM_LSB = 0,
  parameter int FW     = 32,
  parameter int NB     = 2 * DW / RW,
  parameter int BIW    = $clog2(NB + 1)
) (
  input  wcs_phase_e      phase,
  input  logic [BIW-1:0]  blk_idx,
  input  logic [CW-1:0]   pos,
  input  logic [DW-1:0]   seed_q,
  input  logic [DW-1:0]   addr_q,
  input  logic [DW-1:0]   key_q,
  input  logic [DW-1:0]   mask_q,
  input  logic [DW-1:0]   value_q,
  output logic [RW-1:0]   sp_blk
);
  localparam int IW = 2 * DW;

  logic [DW-1:0] addr_mod;
  logic [IW-1:0] call_in;
  logic [RW-1:0] blks [NB];

  always_comb begin
    addr_mod = addr_q;
    addr_mod[HA_LSB +: FW] = FW'(pos);
    addr_mod[KM_LSB +: FW] = (phase == PH_MASK) ? FW'(1) : FW'(0);
  end

  assign call_in = (phase == PH_FN) ? {key_q, value_q ^ mask_q}
                                    : {seed_q, addr_mod};

  for (genvar g = 0; g < NB; g++) begin : g_blk
    assign blks[g] = call_in[IW-1-g*RW -: RW];
  end

  always_comb begin
    sp_blk = '0;
    for (int k = 0; k < NB; k++) begin
      if (blk_idx == BIW'(k)) sp_blk = blks[k];
    end
  end
endmodule

// File: rtl/wcs_regs.sv
module wcs_regs
  import wcs_pkg::*;
#(
  parameter int DW = 256,
  parameter int RW = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          cap_hi,
  input  logic          cap_out,
  input  wcs_phase_e    phase,
  input  logic [DW-1:0] chain_in,
  input  logic [DW-1:0] seed,
  input  logic [DW-1:0] addr,
  input  logic [RW-1:0] sp_out,
  output logic [DW-1:0] seed_q,
  output logic [DW-1:0] addr_q,
  output logic [DW-1:0] key_q,
  output logic [DW-1:0] mask_q,
  output logic [DW-1:0] value_q
);
  logic [RW-1:0] hi_q;
  logic [DW-1:0] call_out;
  logic          en_key, en_mask, en_val;
  logic [DW-1:0] val_n;

  assign call_out = {hi_q, sp_out};
  assign en_key   = cap_out && (phase == PH_KEY);
  assign en_mask  = cap_out && (phase == PH_MASK);
  assign en_val   = accept || (cap_out && (phase == PH_FN));
  assign val_n    = accept ? chain_in : call_out;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seed_q <= '0;
      addr_q <= '0;
    end else if (accept) begin
      seed_q <= seed;
      addr_q <= addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hi_q <= '0;
    else if (cap_hi) hi_q <= sp_out;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      key_q <= '0;
    else if (en_key) key_q <= call_out;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (en_mask) mask_q <= call_out;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      value_q <= '0;
    else if (en_val) value_q <= val_n;
  end

  // R8: the chain value changes only on an accepted request or an F capture
  assert_value_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept && !(cap_out && phase == PH_FN)) |=> $stable(value_q));
endmodule

// File: rtl/wots_chain_seq.sv
module wots_chain_seq
  import wcs_pkg::*;
#(
  parameter int DW     = 256,
  parameter int RW     = 128,
  parameter int CW     = 8,
  parameter int HA_LSB = 32,
  parameter int KM_LSB = 0,
  parameter int FW     = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [DW-1:0] chain_in,
  input  logic [DW-1:0] seed,
  input  logic [DW-1:0] addr,
  input  logic [CW-1:0] pos_i,
  input  logic [CW-1:0] steps_j,
  input  logic [CW-1:0] w_par,
  output logic          busy,
  output logic          done,
  output logic          chain_err,
  output logic [DW-1:0] result,
  output logic          sp_start,
  output logic          sp_cont,
  output logic [RW-1:0] sp_blk,
  input  logic          sp_done,
  input  logic [RW-1:0] sp_out
);
  localparam int NB  = 2 * DW / RW;
  localparam int BIW = $clog2(NB + 1);

  logic           rst_ns;
  wcs_phase_e     phase;
  logic [BIW-1:0] blk_idx;
  logic [CW-1:0]  pos;
  logic           accept, cap_hi, cap_out;
  logic [DW-1:0]  seed_q, addr_q, key_q, mask_q, value_q;

  wcs_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_ns)
  );

  wcs_ctrl #(.CW(CW), .NB(NB), .BIW(BIW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_ns),
    .go        (go),
    .pos_i     (pos_i),
    .steps_j   (steps_j),
    .w_par     (w_par),
    .sp_done   (sp_done),
    .phase     (phase),
    .blk_idx   (blk_idx),
    .pos       (pos),
    .accept    (accept),
    .cap_hi    (cap_hi),
    .cap_out   (cap_out),
    .busy      (busy),
    .done      (done),
    .chain_err (chain_err),
    .sp_start  (sp_start),
    .sp_cont   (sp_cont)
  );

  wcs_msg #(.DW(DW), .RW(RW), .CW(CW), .HA_LSB(HA_LSB), .KM_LSB(KM_LSB),
            .FW(FW), .NB(NB), .BIW(BIW)) u_msg (
    .phase   (phase),
    .blk_idx (blk_idx),
    .pos     (pos),
    .seed_q  (seed_q),
    .addr_q  (addr_q),
    .key_q   (key_q),
    .mask_q  (mask_q),
    .value_q (value_q),
    .sp_blk  (sp_blk)
  );

  wcs_regs #(.DW(DW), .RW(RW)) u_regs (
    .clk      (clk),
    .rst_n    (rst_ns),
    .accept   (accept),
    .cap_hi   (cap_hi),
    .cap_out  (cap_out),
    .phase    (phase),
    .chain_in (chain_in),
    .seed     (seed),
    .addr     (addr),
    .sp_out   (sp_out),
    .seed_q   (seed_q),
    .addr_q   (addr_q),
    .key_q    (key_q),
    .mask_q   (mask_q),
    .value_q  (value_q)
  );

  assign result = value_q;

  // R6: the squeeze request carries an all-zero block
  assert_squeeze_zero_R6: assert property (@(posedge clk) disable iff (!rst_ns)
    (sp_cont && blk_idx == BIW'(NB)) |-> (sp_blk == '0));
  // R2: a rejected request issues no sponge traffic in the following cycle
  assert_err_quiet_R2: assert property (@(posedge clk) disable iff (!rst_ns)
    (go && !busy && !accept) |=> !(sp_start || sp_cont));
endmodule

// File: tb/wots_chain_seq_test.sv
`timescale 1ns/1ps
module wots_chain_seq_test;
  localparam int LAT = 3;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         go;
  logic [255:0] chain_in, seed, addr;
  logic [7:0]   pos_i, steps_j, w_par;
  logic         busy, done, chain_err;
  logic [255:0] result;
  logic         sp_start, sp_cont;
  logic [127:0] sp_blk;
  logic         sp_done;
  logic [127:0] sp_out;

  int n_checks = 0;
  int n_fail   = 0;
  int n_req    = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  wots_chain_seq uut (
    .clk(clk), .rst_n(rst_n), .go(go), .chain_in(chain_in), .seed(seed),
    .addr(addr), .pos_i(pos_i), .steps_j(steps_j), .w_par(w_par),
    .busy(busy), .done(done), .chain_err(chain_err), .result(result),
    .sp_start(sp_start), .sp_cont(sp_cont), .sp_blk(sp_blk),
    .sp_done(sp_done), .sp_out(sp_out)
  );

  function automatic logic [127:0] mixf(input logic [127:0] x);
    logic [127:0] y;
    y = {x[100:0], x[127:101]} ^ {x[63:0], x[127:64]};
    y = y + 128'h9e3779b97f4a7c15f39cc0605cedc834;
    return y ^ {y[126:0], y[127]} ^ (y >> 17);
  endfunction

  function automatic logic [255:0] call_ref(input logic [511:0] in);
    logic [127:0] s, hi;
    s  = mixf(in[511:384]);
    s  = mixf(s ^ in[383:256]);
    s  = mixf(s ^ in[255:128]);
    s  = mixf(s ^ in[127:0]);
    hi = s;
    s  = mixf(s);
    return {hi, s};
  endfunction

  function automatic logic [255:0] chain_ref(input logic [255:0] v0,
      input logic [255:0] sd, input logic [255:0] ad,
      input int i, input int j);
    logic [255:0] v, a, k, m;
    v = v0;
    for (int s = 0; s < j; s++) begin
      a = ad;
      a[63:32] = 32'(i + s);
      a[31:0]  = 32'd0;
      k = call_ref({sd, a});
      a[31:0]  = 32'd1;
      m = call_ref({sd, a});
      v = call_ref({k, v ^ m});
    end
    return v;
  endfunction

  // Sponge stand-in with a fixed latency; checks request framing (R6, R7)
  logic [127:0] sp_st;
  int           sp_cnt;
  int           sp_pos;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_done <= 1'b0;
      sp_out  <= '0;
      sp_st   <= '0;
      sp_cnt  <= 0;
      sp_pos  <= 0;
    end else begin
      sp_done <= 1'b0;
      if (sp_cnt != 0) begin
        sp_cnt <= sp_cnt - 1;
        if (sp_cnt == 1) begin
          sp_done <= 1'b1;
          sp_out  <= sp_st;
        end
      end
      if (sp_start || sp_cont) begin
        n_req = n_req + 1;
        if (sp_cnt != 0 || (sp_start && sp_cont)) begin
          n_fail = n_fail + 1;
          $display("FAIL R7: request overlap cnt=%0d start=%0b cont=%0b exp idle single", sp_cnt, sp_start, sp_cont);
        end
        if (sp_start != (sp_pos == 0)) begin
          n_fail = n_fail + 1;
          $display("FAIL R6: request %0d of call start=%0b expected %0b", sp_pos, sp_start, sp_pos == 0);
        end
        if (sp_pos == 4 && sp_blk != '0) begin
          n_fail = n_fail + 1;
          $display("FAIL R6: squeeze block %h expected 0", sp_blk);
        end
        sp_st  <= sp_start ? mixf(sp_blk) : mixf(sp_st ^ sp_blk);
        sp_cnt <= LAT;
        sp_pos <= (sp_pos == 4) ? 0 : sp_pos + 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [255:0] act,
                       input logic [255:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [255:0] rnd256();
    logic [255:0] r;
    for (int k = 0; k < 8; k++) r[k*32 +: 32] = $urandom;
    return r;
  endfunction

  logic [255:0] last_res;

  task automatic run(input logic [255:0] v0, input logic [255:0] sd,
                     input logic [255:0] ad, input int i, input int j,
                     input int w, input bit poke);
    int req0, t;
    bit bad;
    logic [255:0] expv;
    bad  = (i + j + 1) > w;
    expv = bad ? last_res : chain_ref(v0, sd, ad, i, j);
    req0 = n_req;
    @(negedge clk);
    chain_in = v0; seed = sd; addr = ad;
    pos_i = 8'(i); steps_j = 8'(j); w_par = 8'(w); go = 1'b1;
    @(negedge clk);
    go = 1'b0;
    if (poke) begin
      repeat (7) @(negedge clk);
      chain_in = rnd256(); seed = rnd256(); addr = rnd256();
      pos_i = 8'd1; steps_j = 8'd0; w_par = 8'd16; go = 1'b1;
      @(negedge clk);
      go = 1'b0;
      seed = rnd256();
    end
    t = 0;
    while (!done && !chain_err && t < 20000) begin
      @(negedge clk);
      t++;
    end
    if (bad) begin
      check(chain_err && !done, "R2", {254'd0, chain_err, done}, 256'd2);
      check(result == last_res, "R2", result, last_res);
      check(n_req == req0, "R2", 256'(n_req - req0), 256'd0);
    end else begin
      check(done && !chain_err, "R8", {254'd0, chain_err, done}, 256'd1);
      check(result == expv, j == 0 ? "R3" : (poke ? "R9" : "R5"), result, expv);
      check(n_req - req0 == 15 * j, "R10", 256'(n_req - req0), 256'(15 * j));
      @(negedge clk);
      check(!done && !busy, "R8", {254'd0, done, busy}, 256'd0);
      check(result == expv, "R8", result, expv);
      last_res = expv;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [255:0] b;
    void'($urandom(32'd1234));
    rst_n = 1'b0; go = 1'b0;
    chain_in = '0; seed = '0; addr = '0;
    pos_i = '0; steps_j = '0; w_par = '0;
    last_res = '0;
    repeat (3) @(negedge clk);
    check(!busy && !done && !chain_err && !sp_start && !sp_cont && result == '0,
          "R1", result, 256'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!busy && !done && !chain_err && result == '0, "R1", result, 256'd0);

    // R3: zero steps returns the input unchanged
    b = rnd256();
    run(b, rnd256(), rnd256(), 5, 0, 16, 1'b0);
    // R4 R5 R6: one step, known address pattern in the untouched bits
    run(rnd256(), rnd256(), {256{1'b1}}, 0, 1, 16, 1'b0);
    // R2: range overflow rejected, result unchanged
    run(rnd256(), rnd256(), rnd256(), 10, 6, 16, 1'b0);
    // R2: w of zero always rejected
    run(rnd256(), rnd256(), rnd256(), 0, 0, 0, 1'b0);
    // R2: boundary i+j = w-1 accepted, err cleared
    run(rnd256(), rnd256(), rnd256(), 1, 2, 4, 1'b0);
    check(!chain_err, "R2", {255'd0, chain_err}, 256'd0);
    // R9: go while busy ignored
    run(rnd256(), rnd256(), rnd256(), 3, 3, 16, 1'b1);
    // R4 R5 R10: constrained random chains
    for (int n = 0; n < 8; n++) begin
      int i, j;
      i = int'($urandom % 11);
      j = 1 + int'($urandom % 3);
      if (i + j > 15) j = 15 - i;
      run(rnd256(), rnd256(), rnd256(), i, j, 16, 1'b0);
    end
    // R2: exact overflow by one at w=4
    run(rnd256(), rnd256(), rnd256(), 2, 2, 4, 1'b0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule